// File: doc/BRIEF.md
# Direct-Mapped Translation Cache with Table Walk

This block translates 24-bit virtual addresses into 32-bit physical addresses with 4 KiB pages. The virtual page number, address bits 23:12, indexes a 4096-entry direct-mapped cache of page mappings. When a request hits, the block answers one cycle after it accepts the request. When it misses, the block reads the 32-bit mapping from a page table in memory as two 16-bit words. It then stores the mapping in the cache and answers with the result.

Page bits 11:10 select one of four table base registers, and each base covers 1024 pages. Software programs the bases, their enables and a global translation enable through a byte-wide write port. When software writes a base's enable byte, the 1024 cached entries that the base covers are dropped. While translation is off, addresses pass through unchanged. Physical memory sits outside the block, behind a request/acknowledge read port.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, translation is off, all four bases are disabled and the cache holds no entries. `req_ready` is 1, and both `rsp_valid` and `mem_req` are 0.
- R2: While translation is off (register 0x15 bit 0 = 0), an accepted request answers one cycle later with status OK and `rsp_paddr` = {8'h00, address}. This holds for reads and writes, and no memory read is made.
- R3: On a miss, page bits 11:10 select base n. The mapping address is (base n) OR (page bits 9:0 << 2). The block reads the high 16 bits at the mapping address and then the low 16 bits at the mapping address + 2.
- R4: A mapping with bit 0 set (present) gives status OK and `rsp_paddr` = {mapping bits 31:12, address bits 11:0}.
- R5: A mapping with bit 0 clear gives status NOMAP. A write to a present page whose mapping bit 1 (writable) is clear gives status FAULT, while a read of that page gives OK.
- R6: On a miss whose selected base is disabled, the block answers NOMAP one cycle after acceptance and makes no memory read.
- R7: A completed walk fills the entry, whether the page is present or not. The fill stores the fetched mapping with bit 11 set as the valid tag. A later request to the same page answers one cycle after acceptance with no memory read, and it uses the cached mapping even if memory has changed.
- R8: A write to the enable byte of base n drops every cached entry of pages whose bits 11:10 equal n. Entries under the other bases stay cached.
- R9: If a memory read during the walk returns `mem_err`, the answer is FAULT, the walk stops and the cache entry is not filled. A later request to that page walks again.
- R10: Status codes are 0 = OK, 1 = NOMAP and 2 = FAULT. `rsp_valid` pulses for one cycle for each accepted request. `req_ready` stays low from the acceptance of a walking miss until its answer, so only one walk is outstanding at a time.
- R11: The register map has base n at addresses 4n to 4n+3. Bytes 0 to 2 hold base bits 31:24, 23:16 and 15:8. Byte 3 bit 0 is the base's enable. Address 0x15 bit 0 is the global translation enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Virtual address |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 0 OK, 1 NOMAP, 2 FAULT |
| rsp_paddr | output | 32 | Physical address (valid with OK) |
| mem_req | output | 1 | Table word read requested |
| mem_addr | output | 32 | Physical address of the table word |
| mem_ack | input | 1 | Read completed this cycle |
| mem_err | input | 1 | Completed read failed |
| mem_rdata | input | 16 | Read data |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 8 | Control register address |
| reg_wdata | input | 8 | Control register write data |

## Verification
The bench checks the order and addresses of the two halves of the walk. A swapped order or a missing +2 would return a frame built from the wrong words. It sets up a cached page and then changes the page table, so a design that does not really hit would walk again and return the new frame. It flushes one base and checks that a page under another base still answers in one cycle with no memory read, which catches flushes of the wrong quarter or of the whole cache. It injects read errors on both the high and the low word, and then checks that the next request walks again, which shows that a failed fill was not kept.

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int VA_W  = 24,
  parameter int OFF_W = 12,
  parameter int MW_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_addr,
  input  logic                 req_write,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_status,
  output logic [2*MW_W-1:0]    rsp_paddr,
  output logic                 mem_req,
  output logic [2*MW_W-1:0]    mem_addr,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [MW_W-1:0]      mem_rdata,
  input  logic                 reg_we,
  input  logic [7:0]           reg_addr,
  input  logic [7:0]           reg_wdata
);
  localparam int PA_W   = 2 * MW_W;
  localparam int PAGE_W = VA_W - OFF_W;
  localparam int IDX_W  = PAGE_W - 2;
  localparam int QTR    = 1 << IDX_W;
  localparam int DEPTH  = 4 * QTR;
  localparam int BASE_W = PA_W - 8;
  localparam logic [1:0] ST_OK = 2'd0, ST_NOMAP = 2'd1, ST_FAULT = 2'd2;
  localparam logic [PA_W-1:0] TAG = PA_W'(1) << 11;
  localparam logic [7:0] GLOBAL_REG = 8'h15;

  typedef enum logic [1:0] {IDLE, WHI, WLO} state_t;
  state_t state;

  logic                 xlate_on;
  logic [3:0]           base_en;
  logic [BASE_W-1:0]    base_hi [4];
  logic [QTR-1:0]       tlb_v   [4];
  logic [PA_W-1:0]      tlb_d   [DEPTH];
  logic [VA_W-1:0]      cur_addr;
  logic                 cur_wr;
  logic [MW_W-1:0]      hi_word;

  function automatic logic [PA_W+1:0] judge(input logic [PA_W-1:0] m, input logic wr,
                                            input logic [OFF_W-1:0] off);
    if (!m[0]) return {ST_NOMAP, {PA_W{1'b0}}};
    if (wr && !m[1]) return {ST_FAULT, {PA_W{1'b0}}};
    return {ST_OK, m[PA_W-1:OFF_W], off};
  endfunction

  wire [PAGE_W-1:0] page  = req_addr[VA_W-1:OFF_W];
  wire [1:0]        qsel  = page[PAGE_W-1:IDX_W];
  wire [IDX_W-1:0]  pidx  = page[IDX_W-1:0];
  wire [PA_W-1:0]   hmap  = tlb_d[page];
  wire              hit   = tlb_v[qsel][pidx] & hmap[11];

  wire [PAGE_W-1:0] cpage = cur_addr[VA_W-1:OFF_W];
  wire [1:0]        cq    = cpage[PAGE_W-1:IDX_W];
  wire [IDX_W-1:0]  cidx  = cpage[IDX_W-1:0];
  wire [PA_W-1:0]   maddr = {base_hi[cq], 8'h00} | (PA_W'(cidx) << 2);
  wire [PA_W-1:0]   fmap  = {hi_word, mem_rdata};
  wire              fill  = (state == WLO) && mem_ack && !mem_err;

  wire              breg  = reg_we && (reg_addr[7:4] == 4'h0);
  wire [1:0]        bn    = reg_addr[3:2];

  assign req_ready = (state == IDLE);
  assign mem_req   = (state != IDLE);
  assign mem_addr  = (state == WLO) ? maddr + PA_W'(2) : maddr;

  always_ff @(posedge clk) begin
    if (fill) tlb_d[cpage] <= fmap | TAG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlate_on <= 1'b0;
      base_en  <= '0;
      for (int q = 0; q < 4; q++) begin
        base_hi[q] <= '0;
        tlb_v[q]   <= '0;
      end
    end else begin
      if (fill) tlb_v[cq][cidx] <= 1'b1;
      if (breg) begin
        case (reg_addr[1:0])
          2'd0: base_hi[bn][BASE_W-1 -: 8] <= reg_wdata;
          2'd1: base_hi[bn][BASE_W-9 -: 8] <= reg_wdata;
          2'd2: base_hi[bn][7:0]           <= reg_wdata;
          default: begin
            base_en[bn] <= reg_wdata[0];
            tlb_v[bn]   <= '0;
          end
        endcase
      end
      if (reg_we && reg_addr == GLOBAL_REG) xlate_on <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      cur_addr   <= '0;
      cur_wr     <= 1'b0;
      hi_word    <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          if (!xlate_on) begin
            rsp_valid <= 1'b1;
            {rsp_status, rsp_paddr} <= {ST_OK, PA_W'(req_addr)};
          end else if (hit) begin
            rsp_valid <= 1'b1;
            {rsp_status, rsp_paddr} <= judge(hmap, req_write, req_addr[OFF_W-1:0]);
          end else if (!base_en[qsel]) begin
            rsp_valid <= 1'b1;
            {rsp_status, rsp_paddr} <= {ST_NOMAP, {PA_W{1'b0}}};
          end else begin
            cur_addr <= req_addr;
            cur_wr   <= req_write;
            state    <= WHI;
          end
        end
        WHI: if (mem_ack) begin
          if (mem_err) begin
            rsp_valid <= 1'b1;
            {rsp_status, rsp_paddr} <= {ST_FAULT, {PA_W{1'b0}}};
            state <= IDLE;
          end else begin
            hi_word <= mem_rdata;
            state   <= WLO;
          end
        end
        WLO: if (mem_ack) begin
          rsp_valid <= 1'b1;
          if (mem_err) {rsp_status, rsp_paddr} <= {ST_FAULT, {PA_W{1'b0}}};
          else         {rsp_status, rsp_paddr} <= judge(fmap, cur_wr, cur_addr[OFF_W-1:0]);
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R10
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);
  // R10
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  // R3
  low_half_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && $past(mem_ack) && !$past(mem_err))
      |-> mem_addr == $past(mem_addr) + PA_W'(2));
  // R6
  walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(req_valid && req_ready && xlate_on));
  // R10
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past((req_valid && req_ready) || (mem_req && mem_ack)));
  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlate_on) |=>
      (rsp_valid && rsp_status == ST_OK && rsp_paddr == PA_W'($past(req_addr))));
endmodule

// File: tb/tb_vpage_xlate.sv
`timescale 1ns/1ps
module tb_vpage_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_req;
  logic [1:0] rsp_status;
  logic [31:0] rsp_paddr, mem_addr;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;

  vpage_xlate dut (.*);

  always #4 clk = ~clk;

  logic [15:0] memw [logic [31:0]];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] rd_log [8];
  int rd_count = 0;
  int checks = 0, failures = 0;
  logic [1:0] r_st; logic [31:0] r_pa; int r_cyc, r_reads, r_first; logic r_busy;

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= memw.exists(mem_addr) ? memw[mem_addr] : 16'h0;
      mem_err   <= (mem_addr == err_addr);
      rd_log[rd_count % 8] <= mem_addr;
      rd_count  <= rd_count + 1;
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_map(input logic [31:0] a, input logic [31:0] v);
    memw[a] = v[31:16];
    memw[a + 2] = v[15:0];
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_base(input int n, input logic [31:0] b, input logic en);
    wreg(8'(4*n), b[31:24]);
    wreg(8'(4*n+1), b[23:16]);
    wreg(8'(4*n+2), b[15:8]);
    wreg(8'(4*n+3), {7'b0, en});
  endtask

  task automatic xlate(input logic [23:0] a, input logic wr);
    int s;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    s = rd_count; r_first = s;
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_busy = !req_ready;
    r_cyc = 1;
    while (!rsp_valid && r_cyc < 50) begin @(negedge clk); r_cyc++; end
    r_st = rsp_status; r_pa = rsp_paddr; r_reads = rd_count - s;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_passthru;
    xlate(24'hABCDEF, 1'b1);
    chk("R2 status", 32'(r_st), 0);
    chk("R2 paddr", r_pa, 32'h00ABCDEF);
    chk("R2 latency", r_cyc, 1);
    chk("R2 reads", r_reads, 0);
  endtask

  task automatic t_base_off;
    wreg(8'h15, 8'h01);
    xlate(24'h001234, 1'b0);
    chk("R6 status", 32'(r_st), 1);
    chk("R6 reads", r_reads, 0);
    chk("R6 latency", r_cyc, 1);
  endtask

  task automatic t_walk;
    set_base(0, 32'h0010_0000, 1'b1);
    put_map(32'h0010_0004, 32'h0034_5003);
    xlate(24'h001ABC, 1'b0);
    chk("R4 status", 32'(r_st), 0);
    chk("R4 paddr", r_pa, 32'h0034_5ABC);
    chk("R3 reads", r_reads, 2);
    chk("R3 high addr", rd_log[r_first % 8], 32'h0010_0004);
    chk("R3 low addr", rd_log[(r_first + 1) % 8], 32'h0010_0006);
    chk("R10 ready low in walk", 32'(r_busy), 1);
  endtask

  task automatic t_hit;
    put_map(32'h0010_0004, 32'h0099_9003);
    xlate(24'h001123, 1'b1);
    chk("R7 paddr cached", r_pa, 32'h0034_5123);
    chk("R7 latency", r_cyc, 1);
    chk("R7 reads", r_reads, 0);
  endtask

  task automatic t_readonly;
    put_map(32'h0010_0008, 32'h0077_7001);
    xlate(24'h002010, 1'b1);
    chk("R5 write fault", 32'(r_st), 2);
    xlate(24'h002010, 1'b0);
    chk("R5 read ok", 32'(r_st), 0);
    chk("R5 read paddr", r_pa, 32'h0077_7010);
    chk("R7 nonpresent fill hit", r_reads, 0);
    put_map(32'h0010_000C, 32'h0000_0000);
    xlate(24'h003000, 1'b0);
    chk("R5 nomap", 32'(r_st), 1);
    chk("R5 nomap reads", r_reads, 2);
    put_map(32'h0010_000C, 32'h0012_3003);
    xlate(24'h003000, 1'b0);
    chk("R7 nonpresent cached", 32'(r_st), 1);
    chk("R7 nonpresent no reads", r_reads, 0);
  endtask

  task automatic t_base1;
    set_base(1, 32'h0020_0000, 1'b1);
    put_map(32'h0020_0000, 32'h0ABC_D003);
    xlate(24'h400010, 1'b0);
    chk("R3 base1 addr", rd_log[r_first % 8], 32'h0020_0000);
    chk("R11 base1 paddr", r_pa, 32'h0ABC_D010);
  endtask

  task automatic t_flush;
    wreg(8'h03, 8'h01);
    xlate(24'h001ABC, 1'b0);
    chk("R8 flushed walks", r_reads, 2);
    chk("R8 new mapping", r_pa, 32'h0099_9ABC);
    xlate(24'h400020, 1'b0);
    chk("R8 other quarter kept", r_reads, 0);
    chk("R8 other paddr", r_pa, 32'h0ABC_D020);
  endtask

  task automatic t_memerr;
    put_map(32'h0010_0014, 32'h0055_5003);
    err_addr = 32'h0010_0014;
    xlate(24'h005000, 1'b0);
    chk("R9 high err fault", 32'(r_st), 2);
    chk("R9 high err stops", r_reads, 1);
    err_addr = 32'hFFFF_FFFF;
    xlate(24'h005004, 1'b0);
    chk("R9 no fill rewalk", r_reads, 2);
    chk("R9 retry paddr", r_pa, 32'h0055_5004);
    put_map(32'h0010_0018, 32'h0066_6003);
    err_addr = 32'h0010_001A;
    xlate(24'h006000, 1'b0);
    chk("R9 low err fault", 32'(r_st), 2);
    err_addr = 32'hFFFF_FFFF;
    xlate(24'h006000, 1'b0);
    chk("R9 low err rewalk", r_reads, 2);
  endtask

  task automatic t_disable;
    wreg(8'h03, 8'h00);
    xlate(24'h001ABC, 1'b0);
    chk("R8 disable flush nomap", 32'(r_st), 1);
    chk("R6 disabled no reads", r_reads, 0);
    wreg(8'h15, 8'h00);
    xlate(24'h400020, 1'b0);
    chk("R2 off again paddr", r_pa, 32'h0040_0020);
    chk("R2 off again reads", r_reads, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_passthru;
    t_base_off;
    t_walk;
    t_hit;
    t_readonly;
    t_base1;
    t_flush;
    t_memerr;
    t_disable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule